// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

A purely combinational 64-bit execution stage for register shift and rotate operations. One evaluation takes a source operand, an insert operand, a shift-amount operand, a three-bit operation code, a 32-bit mode flag, a signed flag and two six-bit mask fields. It returns a 64-bit result, a flag saying whether the code was one the unit implements, and a two-bit carry pair.

The rotate family shares a single mask generator. The mask is a run of set bits between a start position and an end position. Positions are counted with 0 as the most significant bit, and a start beyond the end makes the mask wrap around. Rotated data is kept where the mask is set and taken from the insert operand everywhere else. Forms without an insert are issued with a zero insert operand.

An opaque context word and a routing tag travel through the unit unchanged, so that a surrounding pipeline can follow the operation. Operation codes: 0 none, 1 shift left, 2 shift right, 3 rotate word with mask, 4 rotate clear-left, 5 rotate clear-right, 6 rotate clear-immediate, 7 sign-extend then shift left.

Top module: `shrot_unit`

## Requirements
- R1: Shift left (code 1). In 32-bit mode the amount is `amtVal[5:0]`, only the low 32 result bits are kept and bits 63:32 read zero. In 64-bit mode the amount is `amtVal[6:0]`, so any amount of 64 or more gives zero.
- R2: Shift right (code 2). In 32-bit mode it acts on `srcVal[31:0]` with amount `amtVal[5:0]`. In 64-bit mode it acts on all of `srcVal` with amount `amtVal[6:0]`. With `isSigned` high the shift is arithmetic and fills with the sign bit, also across bits 63:32 in 32-bit mode. Otherwise it fills with zeros.
- R3: Both carry bits are set only for a signed right shift of a negative operand that loses at least one 1 bit. The two bits are always equal, and every other case gives 00.
- R4: The mask covers positions start through end, where position p is result bit 63-p. If start > end, the mask covers positions at or above start together with positions at or below end. If start equals end, exactly one bit is set.
- R5: Rotate word (code 3) copies `srcVal[31:0]` into both halves and rotates left by `amtVal[4:0]`. The mask start is `maskBegin[4:0]+32` and the mask end is `maskEnd[4:0]+32`.
- R6: Every rotate returns (rotated AND mask) OR (`insVal` AND NOT mask).
- R7: The 64-bit rotates rotate by `amtVal[5:0]`. They decode a mask field f as the position {f[0], f[5:1]}: bit 0 of the field becomes the most significant bit of the position.
- R8: Clear-left (code 4) uses start = decoded `maskBegin` and end = 63. Clear-right (code 5) uses start = 0 and end = decoded `maskEnd`. Clear-immediate (code 6) uses start = decoded `maskBegin` and end = 63 - `amtVal[5:0]`.
- R9: Code 7 sign-extends `srcVal[31:0]` to 64 bits and then shifts left by `amtVal[5:0]`.
- R10: For code 0, `resValid` is low and both the result and the carry are zero. For codes 1 to 7, `resValid` is high.
- R11: `ctxOut` equals `ctxIn` and `tagOut` equals `tagIn` for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcVal | input | 64 | Source operand |
| insVal | input | 64 | Insert operand for rotates |
| amtVal | input | 64 | Shift or rotate amount operand |
| opCode | input | 3 | Operation code |
| is32 | input | 1 | 32-bit mode |
| isSigned | input | 1 | Arithmetic right shift |
| maskBegin | input | 6 | Mask-begin field |
| maskEnd | input | 6 | Mask-end field |
| ctxIn | input | CTX_W | Operation context |
| tagIn | input | TAG_W | Routing tag |
| resVal | output | 64 | Result |
| resValid | output | 1 | Operation implemented |
| carryOut | output | 2 | Carry pair |
| ctxOut | output | CTX_W | Context passed through |
| tagOut | output | TAG_W | Tag passed through |

## Verification
Two pairs of functions produce their outputs in the same evaluation.

- A signed right shift delivers the shifted value and the lost-bit carry together. Vectors pair a negative operand that drops a 1 bit with one that drops only zeros, and the bench compares both the result and the carry in the same sample.
- A rotate with a wrapped or partial mask also merges the insert operand. A word rotate whose begin field exceeds its end field, and clear-immediate and word-insert cases with a non-zero insert operand, show each result bit coming from the correct source.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_SHL   = 3'd1,
    OP_SHR   = 3'd2,
    OP_ROT32 = 3'd3,
    OP_RCL   = 3'd4,
    OP_RCR   = 3'd5,
    OP_RCI   = 3'd6,
    OP_EXTSH = 3'd7
  } shrot_op_e;

  typedef struct packed {
    logic             valid;
    logic             selShl;
    logic             selShr;
    logic             selRot;
    logic             selExt;
    logic             rot32;
    logic [POS_W-1:0] maskStart;
    logic [POS_W-1:0] maskStop;
  } shrot_ctl_t;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [2:0]       opCode,
  input  logic [POS_W-1:0] maskBegin,
  input  logic [POS_W-1:0] maskEnd,
  input  logic [POS_W-1:0] amtLow,
  output shrot_ctl_t       ctl
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W - 1);

  logic [POS_W-1:0] swzBegin;
  logic [POS_W-1:0] swzEnd;

  // field bit 0 becomes the position MSB
  assign swzBegin = {maskBegin[0], maskBegin[POS_W-1:1]};
  assign swzEnd   = {maskEnd[0], maskEnd[POS_W-1:1]};

  always_comb begin
    ctl = '0;
    unique case (shrot_op_e'(opCode))
      OP_SHL: begin
        ctl.valid  = 1'b1;
        ctl.selShl = 1'b1;
      end
      OP_SHR: begin
        ctl.valid  = 1'b1;
        ctl.selShr = 1'b1;
      end
      OP_ROT32: begin
        ctl.valid     = 1'b1;
        ctl.selRot    = 1'b1;
        ctl.rot32     = 1'b1;
        ctl.maskStart = {1'b1, maskBegin[POS_W-2:0]};
        ctl.maskStop  = {1'b1, maskEnd[POS_W-2:0]};
      end
      OP_RCL: begin
        ctl.valid     = 1'b1;
        ctl.selRot    = 1'b1;
        ctl.maskStart = swzBegin;
        ctl.maskStop  = LAST_POS;
      end
      OP_RCR: begin
        ctl.valid     = 1'b1;
        ctl.selRot    = 1'b1;
        ctl.maskStart = '0;
        ctl.maskStop  = swzEnd;
      end
      OP_RCI: begin
        ctl.valid     = 1'b1;
        ctl.selRot    = 1'b1;
        ctl.maskStart = swzBegin;
        ctl.maskStop  = LAST_POS - amtLow;
      end
      OP_EXTSH: begin
        ctl.valid  = 1'b1;
        ctl.selExt = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    if (ctl.valid) begin
      a_r10_one_select: assert ($onehot0({ctl.selShl, ctl.selShr, ctl.selRot, ctl.selExt})
                                && (ctl.selShl | ctl.selShr | ctl.selRot | ctl.selExt))
        else $error("R10: valid op without exactly one select");
    end
  end
endmodule

// File: rtl/shrot_mask.sv
module shrot_mask
  import shrot_pkg::*;
(
  input  logic [POS_W-1:0]  startPos,
  input  logic [POS_W-1:0]  stopPos,
  output logic [DATA_W-1:0] mask
);
  logic wrap;
  assign wrap = startPos > stopPos;

  for (genvar p = 0; p < DATA_W; p++) begin : g_pos
    localparam logic [POS_W-1:0] POS = POS_W'(p);
    logic geStart;
    logic leStop;
    assign geStart = POS >= startPos;
    assign leStop  = POS <= stopPos;
    // position p is result bit DATA_W-1-p
    assign mask[DATA_W-1-p] = wrap ? (geStart | leStop) : (geStart & leStop);
  end

  always_comb begin
    if (startPos == stopPos) begin
      a_r4_single_bit: assert ($countones(mask) == 1)
        else $error("R4: equal ends must give one bit");
    end
    if (startPos == stopPos + POS_W'(1)) begin
      a_r4_wrap_full: assert (&mask)
        else $error("R4: adjacent wrap must cover all bits");
    end
  end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
(
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] insVal,
  input  logic [6:0]        amtLow,
  input  logic              is32,
  input  logic              isSigned,
  input  shrot_ctl_t        ctl,
  output logic [DATA_W-1:0] result,
  output logic [1:0]        carry
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] mask;
  logic [6:0]        shAmt;
  logic [WIDE_W-1:0] shlWide;
  logic [DATA_W-1:0] shlRes;
  logic [WIDE_W-1:0] shrBase;
  logic signed [WIDE_W-1:0] shrWide;
  logic [WIDE_W-1:0] lostMask;
  logic              lostAny;
  logic              carryBit;
  logic [DATA_W-1:0] rotIn;
  logic [POS_W-1:0]  rotAmt;
  logic [WIDE_W-1:0] rotWide;
  logic [DATA_W-1:0] rotRes;
  logic [DATA_W-1:0] mergeRes;
  logic [DATA_W-1:0] extRes;

  shrot_mask u_mask (
    .startPos (ctl.maskStart),
    .stopPos  (ctl.maskStop),
    .mask     (mask)
  );

  always_comb begin
    shAmt   = is32 ? {1'b0, amtLow[5:0]} : amtLow;
    // left shift
    shlWide = {{DATA_W{1'b0}}, srcVal} << shAmt;
    shlRes  = is32 ? {{HALF_W{1'b0}}, shlWide[HALF_W-1:0]} : shlWide[DATA_W-1:0];
    // right shift on a widened operand
    if (is32)
      shrBase = {{(WIDE_W-HALF_W){isSigned & srcVal[HALF_W-1]}}, srcVal[HALF_W-1:0]};
    else
      shrBase = {{DATA_W{isSigned & srcVal[DATA_W-1]}}, srcVal};
    shrWide  = $signed(shrBase) >>> shAmt;
    lostMask = ~({WIDE_W{1'b1}} << shAmt);
    lostAny  = |(shrBase & lostMask);
    carryBit = ctl.selShr & isSigned & shrBase[WIDE_W-1] & lostAny;
    // rotate and merge
    rotIn    = ctl.rot32 ? {srcVal[HALF_W-1:0], srcVal[HALF_W-1:0]} : srcVal;
    rotAmt   = ctl.rot32 ? {1'b0, amtLow[POS_W-2:0]} : amtLow[POS_W-1:0];
    rotWide  = {rotIn, rotIn} << rotAmt;
    rotRes   = rotWide[WIDE_W-1:DATA_W];
    mergeRes = (rotRes & mask) | (insVal & ~mask);
    // sign-extend then shift
    extRes   = {{HALF_W{srcVal[HALF_W-1]}}, srcVal[HALF_W-1:0]} << amtLow[POS_W-1:0];

    result = '0;
    if (ctl.selShl) result = shlRes;
    if (ctl.selShr) result = shrWide[DATA_W-1:0];
    if (ctl.selRot) result = mergeRes;
    if (ctl.selExt) result = extRes;
    carry = {carryBit, carryBit};
  end

  always_comb begin
    if (ctl.selShl && is32) begin
      a_r1_shl32_upper_zero: assert (result[DATA_W-1:HALF_W] == '0)
        else $error("R1: upper word not zero");
    end
    a_r3_carry_pair: assert (carry[1] == carry[0])
      else $error("R3: carry bits differ");
    if (carry[0]) begin
      a_r3_carry_source: assert (ctl.selShr && isSigned)
        else $error("R3: carry outside signed right shift");
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int CTX_W = 16,
  parameter int TAG_W = 2
) (
  input  logic [63:0]      srcVal,
  input  logic [63:0]      insVal,
  input  logic [63:0]      amtVal,
  input  logic [2:0]       opCode,
  input  logic             is32,
  input  logic             isSigned,
  input  logic [5:0]       maskBegin,
  input  logic [5:0]       maskEnd,
  input  logic [CTX_W-1:0] ctxIn,
  input  logic [TAG_W-1:0] tagIn,
  output logic [63:0]      resVal,
  output logic             resValid,
  output logic [1:0]       carryOut,
  output logic [CTX_W-1:0] ctxOut,
  output logic [TAG_W-1:0] tagOut
);
  shrot_ctl_t ctl;
  logic       unusedAmtHi;

  assign unusedAmtHi = ^amtVal[63:7];

  shrot_ctrl u_ctrl (
    .opCode    (opCode),
    .maskBegin (maskBegin),
    .maskEnd   (maskEnd),
    .amtLow    (amtVal[POS_W-1:0]),
    .ctl       (ctl)
  );

  shrot_datapath u_dp (
    .srcVal   (srcVal),
    .insVal   (insVal),
    .amtLow   (amtVal[6:0]),
    .is32     (is32),
    .isSigned (isSigned),
    .ctl      (ctl),
    .result   (resVal),
    .carry    (carryOut)
  );

  assign resValid = ctl.valid;
  assign ctxOut   = ctxIn;
  assign tagOut   = tagIn;

  always_comb begin
    if (!resValid) begin
      a_r10_idle_zero: assert (resVal == '0 && carryOut == 2'b00)
        else $error("R10: unimplemented op drove outputs");
    end
  end
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  typedef struct packed {
    logic [63:0] src;
    logic [63:0] ins;
    logic [63:0] amt;
    logic [2:0]  op;
    logic        w32;
    logic        sgn;
    logic [5:0]  mb;
    logic [5:0]  me;
    logic [63:0] expRes;
    logic [1:0]  expCy;
    logic        expVal;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R1: 64-bit left
    '{64'h1, 64'h0, 64'd4, 3'd1, 1'b0, 1'b0, 6'd0, 6'd0, 64'h10, 2'b00, 1'b1, 8'd1},
    // R1: amount 64 clears
    '{64'h1, 64'h0, 64'd64, 3'd1, 1'b0, 1'b0, 6'd0, 6'd0, 64'h0, 2'b00, 1'b1, 8'd1},
    // R1: 32-bit, amount 0x41 uses low 6 bits
    '{64'h8000_0001, 64'h0, 64'h41, 3'd1, 1'b1, 1'b0, 6'd0, 6'd0, 64'h2, 2'b00, 1'b1, 8'd1},
    // R2: logical right
    '{64'h8000_0000_0000_0000, 64'h0, 64'd63, 3'd2, 1'b0, 1'b0, 6'd0, 6'd0, 64'h1, 2'b00, 1'b1, 8'd2},
    // R3: negative, only zeros lost
    '{64'h8000_0000_0000_0000, 64'h0, 64'd4, 3'd2, 1'b0, 1'b1, 6'd0, 6'd0, 64'hF800_0000_0000_0000, 2'b00, 1'b1, 8'd3},
    // R3: negative, a one lost
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd1, 3'd2, 1'b0, 1'b1, 6'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 8'd3},
    // R2: 32-bit arithmetic fill
    '{64'h8000_0010, 64'h0, 64'd4, 3'd2, 1'b1, 1'b1, 6'd0, 6'd0, 64'hFFFF_FFFF_F800_0001, 2'b00, 1'b1, 8'd2},
    // R3: 32-bit arithmetic with lost one
    '{64'h8000_0011, 64'h0, 64'd4, 3'd2, 1'b1, 1'b1, 6'd0, 6'd0, 64'hFFFF_FFFF_F800_0001, 2'b11, 1'b1, 8'd3},
    // R3: positive operand never carries
    '{64'h7, 64'h0, 64'd1, 3'd2, 1'b0, 1'b1, 6'd0, 6'd0, 64'h3, 2'b00, 1'b1, 8'd3},
    // R5: word rotate, full low-word mask
    '{64'h1234_5678, 64'h0, 64'd8, 3'd3, 1'b1, 1'b0, 6'd0, 6'd31, 64'h3456_7812, 2'b00, 1'b1, 8'd5},
    // R6: word rotate inserting into low byte
    '{64'hFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'd0, 3'd3, 1'b1, 1'b0, 6'd24, 6'd31, 64'hAAAA_AAAA_AAAA_AAFF, 2'b00, 1'b1, 8'd6},
    // R4: wrapped mask, start 63 end 32
    '{64'hFFFF_FFFF, 64'h0, 64'd0, 3'd3, 1'b1, 1'b0, 6'd31, 6'd0, 64'hFFFF_FFFF_8000_0001, 2'b00, 1'b1, 8'd4},
    // R7: clear-left, field 0x39 decodes to 60
    '{64'hF000_0000_0000_000F, 64'h0, 64'd4, 3'd4, 1'b0, 1'b0, 6'h39, 6'd0, 64'hF, 2'b00, 1'b1, 8'd7},
    // R8: clear-right, field 0x0E decodes to 7
    '{64'h0123_4567_89AB_CDEF, 64'h0, 64'd0, 3'd5, 1'b0, 1'b0, 6'd0, 6'h0E, 64'h0100_0000_0000_0000, 2'b00, 1'b1, 8'd8},
    // R8: clear-immediate end 55, insert low byte
    '{64'hFF, 64'h55, 64'd8, 3'd6, 1'b0, 1'b0, 6'd0, 6'd0, 64'hFF55, 2'b00, 1'b1, 8'd8},
    // R9: sign-extend then shift
    '{64'h8000_0001, 64'h0, 64'd4, 3'd7, 1'b0, 1'b0, 6'd0, 6'd0, 64'hFFFF_FFF8_0000_0010, 2'b00, 1'b1, 8'd9},
    // R10: no operation
    '{64'hDEAD_BEEF, 64'h1, 64'd3, 3'd0, 1'b0, 1'b1, 6'd5, 6'd9, 64'h0, 2'b00, 1'b0, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] srcVal = '0, insVal = '0, amtVal = '0;
  logic [2:0]  opCode = '0;
  logic        is32 = 1'b0, isSigned = 1'b0;
  logic [5:0]  maskBegin = '0, maskEnd = '0;
  logic [15:0] ctxIn = '0;
  logic [1:0]  tagIn = '0;
  logic [63:0] resVal;
  logic        resValid;
  logic [1:0]  carryOut;
  logic [15:0] ctxOut;
  logic [1:0]  tagOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shrot_unit u_shrot_unit (
    .srcVal, .insVal, .amtVal, .opCode, .is32, .isSigned,
    .maskBegin, .maskEnd, .ctxIn, .tagIn,
    .resVal, .resValid, .carryOut, .ctxOut, .tagOut
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    srcVal = v.src; insVal = v.ins; amtVal = v.amt; opCode = v.op;
    is32 = v.w32; isSigned = v.sgn; maskBegin = v.mb; maskEnd = v.me;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: idle state under reset
    check("R10 reset result", resVal, 64'h0);
    check("R10 reset valid", {63'b0, resValid}, 64'h0);
    check("R10 reset carry", {62'b0, carryOut}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), resVal, VECS[i].expRes);
      check($sformatf("R%0d vec %0d carry", VECS[i].req, i), {62'b0, carryOut}, {62'b0, VECS[i].expCy});
      check($sformatf("R%0d vec %0d valid", VECS[i].req, i), {63'b0, resValid}, {63'b0, VECS[i].expVal});
    end

    // R4: equal ends give one bit (position 37 -> bit 26)
    apply('{64'hFFFF_FFFF, 64'h0, 64'd0, 3'd3, 1'b1, 1'b0, 6'd5, 6'd5, 64'h0, 2'b00, 1'b1, 8'd4});
    check("R4 single bit", resVal, 64'h0400_0000);
    // R8: clear-left from 0 keeps everything
    apply('{64'h0123_4567_89AB_CDEF, 64'hFFFF, 64'd0, 3'd4, 1'b0, 1'b0, 6'd0, 6'd0, 64'h0, 2'b00, 1'b1, 8'd8});
    check("R8 clear-left full", resVal, 64'h0123_4567_89AB_CDEF);
    // R7: 64-bit rotate uses 6 amount bits (0x44 -> 4)
    apply('{64'hF000_0000_0000_000F, 64'h0, 64'h44, 3'd4, 1'b0, 1'b0, 6'h39, 6'd0, 64'h0, 2'b00, 1'b1, 8'd7});
    check("R7 amount low bits", resVal, 64'hF);
    // R2: unsigned 64-bit right by 100 clears
    apply('{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd100, 3'd2, 1'b0, 1'b0, 6'd0, 6'd0, 64'h0, 2'b00, 1'b1, 8'd2});
    check("R2 wide amount", resVal, 64'h0);
    check("R3 unsigned carry", {62'b0, carryOut}, 64'h0);
    // R11: pass-through of context and tag
    @(negedge clk);
    ctxIn = 16'hBEEF; tagIn = 2'd2;
    #2;
    check("R11 context", {48'b0, ctxOut}, 64'hBEEF);
    check("R11 tag", {62'b0, tagOut}, 64'h2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule